// File: doc/BRIEF.md
# DVMA Page Table Translation Unit

This block maps a 32-bit device virtual address onto a physical address by reading one page-table entry from memory. A request presents the virtual address and a read/write flag. The block clears the translation-window bits from the address and forms the entry address from a base register value and the virtual page number. It then fetches the entry through a simple memory read master and returns the physical address with status flags.

Only one request is in flight at a time. When translation is switched off, the address is returned unchanged and memory is not accessed. Entry caching, bus arbitration and the data transfer itself are handled elsewhere.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: With `xlate_en` = 1, the fetch address is `(base_reg << 4) + (((req_addr & ~win_start) >> 12) << 2)`, modulo 2^32. Each 4 KB page has a 4-byte entry.
- R3: `mem_req` rises in the cycle after a request is accepted. It stays high, with `mem_addr` stable, until `mem_ready` is sampled high.
- R4: The translated `rsp_paddr` is `((entry & 32'h07FFFF00) << 4) + (masked_addr & 32'hFFF)`. The low 12 bits are the page offset.
- R5: `rsp_valid` is high for exactly one cycle, in the cycle after the `mem_ready` handshake. The unit is idle again in the cycle after that.
- R6: `rsp_fault` is 1 exactly when bit 1 (valid) of the fetched entry is 0.
- R7: `rsp_writeable` equals entry bit 2. `rsp_cacheable` equals entry bit 7. `rsp_wr_viol` is 1 exactly when the request was a write and entry bit 2 is 0.
- R8: With `xlate_en` = 0 at acceptance, no fetch is made. `rsp_valid` pulses in the next cycle with `rsp_paddr` = `req_addr`, fault 0, write violation 0, writeable 1 and cacheable 0.
- R9: A request is accepted only while `req_ready` is 1. A `req_valid` asserted while busy has no effect on the current response.
- R10: Entry bits 31:27, 6:3 and 0 have no effect on any response field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable, sampled at acceptance |
| base_reg | input | 32 | Page-table base register value |
| win_start | input | 32 | Window start; these bits are cleared from the address |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| req_ready | output | 1 | Unit idle, request accepted |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Entry read address |
| mem_ready | input | 1 | Entry read completes this cycle |
| mem_rdata | input | 32 | Entry read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Entry not valid |
| rsp_wr_viol | output | 1 | Write to a non-writeable page |
| rsp_cacheable | output | 1 | Entry cacheable bit |
| rsp_writeable | output | 1 | Entry writeable bit |

## Verification
The assertions run on every cycle and cover the handshake. They check that the fetch request holds its address until ready and that the response strobe lasts one cycle and follows the handshake. They also check that the idle, fetch and response phases never overlap, and that bypass returns the input address one cycle later. The arithmetic can only be shown by the bench scenarios, which compare against independently computed values. This covers entry address formation across all window sizes, physical address assembly, the fault and write-violation flags and the ignored entry bits. The bench scenarios also show that requests arriving while busy are ignored.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } xl_state_e;

  typedef struct packed {
    logic fault;
    logic wr_viol;
    logic cacheable;
    logic writeable;
  } xl_flags_t;

  localparam int unsigned PTE_VALID_BIT = 1;
  localparam int unsigned PTE_WRITE_BIT = 2;
  localparam int unsigned PTE_CACHE_BIT = 7;
endpackage

// File: rtl/dvma_index.sv
module dvma_index #(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PTE_LOG2   = 2,
  parameter int unsigned BASE_SHIFT = 4
) (
  input  logic [AW-1:0]         vaddr,
  input  logic [AW-1:0]         base,
  input  logic [AW-1:0]         win,
  output logic [AW-1:0]         ent_addr,
  output logic [PAGE_SHIFT-1:0] offset
);
  logic [AW-1:0] masked;
  logic [AW-1:0] vpn;

  always_comb begin
    masked   = vaddr & ~win;
    vpn      = masked >> PAGE_SHIFT;
    ent_addr = (base << BASE_SHIFT) + (vpn << PTE_LOG2);
    offset   = masked[PAGE_SHIFT-1:0];
  end
endmodule

// File: rtl/dvma_pte_decode.sv
module dvma_pte_decode
  import dvma_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PPN_LSB    = 8,
  parameter int unsigned PPN_MSB    = 26,
  parameter int unsigned PPN_SHIFT  = 4
) (
  input  logic [AW-1:0]         pte,
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic                  is_write,
  output logic [AW-1:0]         paddr,
  output xl_flags_t             flags
);
  logic [AW-1:0] ppn_mask;

  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign ppn_mask[i] = (i >= PPN_LSB) && (i <= PPN_MSB);
  end

  always_comb begin
    paddr           = ((pte & ppn_mask) << PPN_SHIFT)
                      + {{(AW-PAGE_SHIFT){1'b0}}, offset};
    flags.fault     = ~pte[PTE_VALID_BIT];
    flags.writeable = pte[PTE_WRITE_BIT];
    flags.cacheable = pte[PTE_CACHE_BIT];
    flags.wr_viol   = is_write & ~pte[PTE_WRITE_BIT];
  end
endmodule

// File: rtl/dvma_fsm.sv
module dvma_fsm
  import dvma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic xlate_en,
  input  logic mem_ready,
  output logic req_ready,
  output logic mem_req,
  output logic rsp_valid,
  output logic accept_xl,
  output logic accept_bp,
  output logic fetch_done
);
  xl_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    req_ready  = (state_q == ST_IDLE);
    mem_req    = (state_q == ST_FETCH);
    rsp_valid  = (state_q == ST_DONE);
    accept_xl  = 1'b0;
    accept_bp  = 1'b0;
    fetch_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (xlate_en) begin
            accept_xl = 1'b1;
            state_d   = ST_FETCH;
          end else begin
            accept_bp = 1'b1;
            state_d   = ST_DONE;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ready) begin
          fetch_done = 1'b1;
          state_d    = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PTE_LOG2   = 2,
  parameter int unsigned BASE_SHIFT = 4,
  parameter int unsigned PPN_LSB    = 8,
  parameter int unsigned PPN_MSB    = 26,
  parameter int unsigned PPN_SHIFT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xlate_en,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] win_start,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic          rsp_wr_viol,
  output logic          rsp_cacheable,
  output logic          rsp_writeable
);
  localparam xl_flags_t BYPASS_FLAGS = '{fault: 1'b0, wr_viol: 1'b0,
                                         cacheable: 1'b0, writeable: 1'b1};

  logic                  accept_xl, accept_bp, fetch_done;
  logic [AW-1:0]         ent_addr;
  logic [PAGE_SHIFT-1:0] offset_c, offset_q;
  logic                  write_q;
  logic [AW-1:0]         xl_paddr;
  xl_flags_t             xl_flags;
  logic [AW-1:0]         paddr_d, paddr_q;
  xl_flags_t             flags_d, flags_q;
  logic                  rsp_load;

  dvma_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .xlate_en   (xlate_en),
    .mem_ready  (mem_ready),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .rsp_valid  (rsp_valid),
    .accept_xl  (accept_xl),
    .accept_bp  (accept_bp),
    .fetch_done (fetch_done)
  );

  dvma_index #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .PTE_LOG2(PTE_LOG2), .BASE_SHIFT(BASE_SHIFT)
  ) u_index (
    .vaddr    (req_addr),
    .base     (base_reg),
    .win      (win_start),
    .ent_addr (ent_addr),
    .offset   (offset_c)
  );

  dvma_pte_decode #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .PPN_LSB(PPN_LSB),
    .PPN_MSB(PPN_MSB), .PPN_SHIFT(PPN_SHIFT)
  ) u_decode (
    .pte      (mem_rdata),
    .offset   (offset_q),
    .is_write (write_q),
    .paddr    (xl_paddr),
    .flags    (xl_flags)
  );

  // Request capture: entry address, page offset and access type.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      offset_q <= '0;
      write_q  <= 1'b0;
    end else if (accept_xl) begin
      mem_addr <= ent_addr;
      offset_q <= offset_c;
      write_q  <= req_write;
    end
  end

  // Response source select.
  always_comb begin
    rsp_load = accept_bp | fetch_done;
    if (accept_bp) begin
      paddr_d = req_addr;
      flags_d = BYPASS_FLAGS;
    end else begin
      paddr_d = xl_paddr;
      flags_d = xl_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      flags_q <= '0;
    end else if (rsp_load) begin
      paddr_q <= paddr_d;
      flags_q <= flags_d;
    end
  end

  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = flags_q.fault;
  assign rsp_wr_viol   = flags_q.wr_viol;
  assign rsp_cacheable = flags_q.cacheable;
  assign rsp_writeable = flags_q.writeable;
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlate_en,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr
);
  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  a_r3_fetch_starts: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xlate_en |=> mem_req);

  a_r5_rsp_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> rsp_valid);

  a_r5_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r9_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, mem_req, rsp_valid}) == 1);

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlate_en |=>
      rsp_valid && !mem_req && (rsp_paddr == $past(req_addr)));
endmodule

bind dvma_xlate dvma_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xlate_en  (xlate_en),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr)
);

// File: tb/dvma_xlate_test.sv
`timescale 1ns/1ps
module dvma_xlate_test;
  logic        clk, rst_n;
  logic        xlate_en, req_valid, req_write, mem_ready;
  logic [31:0] base_reg, win_start, req_addr, mem_rdata;
  logic        req_ready, mem_req, rsp_valid;
  logic [31:0] mem_addr, rsp_paddr;
  logic        rsp_fault, rsp_wr_viol, rsp_cacheable, rsp_writeable;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  dvma_xlate uut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .base_reg(base_reg),
    .win_start(win_start), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_wr_viol(rsp_wr_viol), .rsp_cacheable(rsp_cacheable),
    .rsp_writeable(rsp_writeable)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [31:0] w,
                                         input logic [31:0] a);
    logic [31:0] m;
    m = a & ~w;
    return (b << 4) + ((m >> 10) & ~32'd3);
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] p, input logic [31:0] w,
                                         input logic [31:0] a);
    logic [31:0] m;
    m = a & ~w;
    return ((p & 32'h07FFFF00) << 4) + (m & 32'h00000FFF);
  endfunction

  function automatic logic [31:0] win_of(input int k);
    return ~((32'd1 << (24 + k)) - 32'd1);
  endfunction

  // flags packed as {fault, wr_viol, cacheable, writeable}
  task automatic run_one(input logic [31:0] addr, input bit wr, input bit en,
                         input logic [31:0] base, input logic [31:0] win,
                         input logic [31:0] pte, input int delay, input bit poke);
    logic [31:0] ea, pa;
    logic [3:0]  fl, ef;
    ea = exp_ea(base, win, addr);
    pa = exp_pa(pte, win, addr);
    ef = {~pte[1], wr & ~pte[2], pte[7], pte[2]};
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; xlate_en = en;
    base_reg = base; win_start = win;
    chk(req_ready === 1'b1, "R9 ready before accept", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (poke) begin
      req_addr = ~addr; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    if (!en) begin
      fl = {rsp_fault, rsp_wr_viol, rsp_cacheable, rsp_writeable};
      chk(mem_req === 1'b0, "R8 no fetch", {31'd0, mem_req}, 32'd0);
      chk(rsp_valid === 1'b1, "R8 rsp strobe", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_paddr === addr, "R8 passthrough addr", rsp_paddr, addr);
      chk(fl === 4'b0001, "R8 bypass flags", {28'd0, fl}, 32'd1);
      req_valid = 1'b0;
    end else begin
      chk(mem_req === 1'b1, "R3 fetch raised", {31'd0, mem_req}, 32'd1);
      chk(mem_addr === ea, "R2 entry address", mem_addr, ea);
      for (int i = 0; i < delay; i++) begin
        mem_rdata = $urandom;
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === ea, "R3 fetch held", mem_addr, ea);
        chk(rsp_valid === 1'b0, "R5 no early rsp", {31'd0, rsp_valid}, 32'd0);
      end
      mem_ready = 1'b1; mem_rdata = pte;
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = $urandom; req_valid = 1'b0;
      fl = {rsp_fault, rsp_wr_viol, rsp_cacheable, rsp_writeable};
      chk(rsp_valid === 1'b1, "R5 rsp after ready", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_paddr === pa, poke ? "R9 busy req ignored" : "R4 paddr", rsp_paddr, pa);
      chk(fl[3] === ef[3], "R6 fault", {31'd0, fl[3]}, {31'd0, ef[3]});
      chk(fl[2:0] === ef[2:0], "R7 viol/cache/write", {29'd0, fl[2:0]}, {29'd0, ef[2:0]});
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R5 single strobe then idle",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; xlate_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    mem_ready = 1'b0; base_reg = '0; win_start = '0; req_addr = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && rsp_valid === 1'b0, "R1 reset state",
        {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    run_one(32'hFF001234, 1'b1, 1'b1, 32'h00001000, win_of(0), 32'h00123486, 0, 1'b0);
    run_one(32'hFF002ABC, 1'b0, 1'b1, 32'h00001000, win_of(0), 32'h00123480, 2, 1'b0);
    run_one(32'hF8123456, 1'b1, 1'b1, 32'h00040000, win_of(3), 32'h07FFFF02, 1, 1'b0);
    run_one(32'hF8123456, 1'b0, 1'b1, 32'h00040000, win_of(3), 32'h07FFFF02, 0, 1'b0);
    run_one(32'h7FFFFFFF, 1'b0, 1'b1, 32'h07FFFC00, win_of(7), 32'h00000086, 5, 1'b0);
    run_one(32'h12345678, 1'b1, 1'b0, 32'h00001000, win_of(0), 32'h0, 0, 1'b0);
    run_one(32'hFE00F00D, 1'b0, 1'b1, 32'h00008000, win_of(1), 32'h04050606, 3, 1'b1);
    run_one(32'hABCDEF01, 1'b0, 1'b0, 32'h00008000, win_of(1), 32'h0, 0, 1'b1);
    // R10: entry noise bits must not change any response field
    run_one(32'hFF00A123, 1'b1, 1'b1, 32'h00002000, win_of(0), 32'hF8ABCD79, 0, 1'b0);
    run_one(32'hFF00A123, 1'b1, 1'b1, 32'h00002000, win_of(0), 32'h00ABCD00, 0, 1'b0);
    // constrained random
    for (int n = 0; n < 400; n++) begin
      run_one($urandom, 1'($urandom), ($urandom % 8) != 0,
              $urandom & 32'h07FFFC00, win_of($urandom % 8), $urandom,
              $urandom % 4, ($urandom % 6) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule